// File: doc/BRIEF.md
# CAM Configuration Register and Address Sequencer

This block is the configuration and addressing front end of a content-addressable memory. It keeps a 15-bit configuration word in each of two banks, foreground and background. A stored selector decides which bank is active, and only the active bank is written, read back and exported to the rest of the device. Software reaches the word through the low half of a 32-bit data bus. A read returns the upper half of the device status word alongside the active configuration word.

A configuration write whose bit 15 is clear does not store data. It is a soft reset that returns the block to its power-up state. Every other configuration write stores bits 14:0 into the active bank and raises a one-cycle automatic compare request. The block also owns the memory address register. After each memory access the register steps up, steps down or holds, according to bits 3:2 of the active word, and it wraps modulo the array depth.

All access pins are plain strobes. No data stream crosses the block's edge, so there is no valid/ready back-pressure. A strobe is taken in the cycle in which it is high.

Top module: `cam_cfg_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, both banks hold `RST_WORD`, the foreground bank (selector 0) is active, `addr_o` is 0, and `cmp_req_o` and `soft_rst_o` are low.
- R2: A write (`ctl_wr`) with `ctl_wdata[15]` = 0 ignores bits 14:0. It returns both banks, the selector and the address to their R1 values, and in the next cycle it raises `soft_rst_o` for exactly one cycle. A soft reset overrides a bank select or an address load made in the same cycle.
- R3: `ctl_rdata[31:16]` equals `status_hi`, `ctl_rdata[14:0]` equals the active word, and `ctl_rdata[15]` is always 0. `cfg_o` equals `ctl_rdata[15:0]`.
- R4: A write with `ctl_wdata[15]` = 1 stores `ctl_wdata[14:0]` into the active bank only. `cmp_req_o` is high for the one cycle that follows that write, and it is never high after a soft-reset write.
- R5: `bank_set` loads the selector from `bank_val` (0 = foreground, 1 = background). A write in the same cycle goes to the bank that was active before the selector changed.
- R6: On `mem_access`, the step field (bits 3:2 of the active word as it was before the edge) moves `addr_o` up by one for 01, down by one for 10, and leaves it unchanged for 00 or 11.
- R7: Stepping up from `DEPTH-1` gives 0, and stepping down from 0 gives `DEPTH-1`. `addr_o` is always below `DEPTH`.
- R8: `addr_ld` loads `addr_ld_val` when that value is below `DEPTH`, and ignores it otherwise. A load takes priority over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| ctl_wr | input | 1 | Configuration write strobe |
| ctl_wdata | input | 32 | Write data; bits 15:0 are used |
| status_hi | input | 16 | Upper status bits returned on reads |
| ctl_rdata | output | 32 | Readback: status bits and active word |
| bank_set | input | 1 | Load the bank selector |
| bank_val | input | 1 | New selector value |
| mem_access | input | 1 | A memory access completed; step the address |
| addr_ld | input | 1 | Load the address register |
| addr_ld_val | input | AW | Address to load |
| addr_o | output | AW | Current memory address |
| cfg_o | output | 16 | Active configuration word, bit 15 zero |
| cmp_req_o | output | 1 | One-cycle automatic compare request |
| soft_rst_o | output | 1 | One-cycle soft reset indication |

## Verification
The bench builds the block with `DEPTH` = 12. This is not a power of two, so the wrap in both directions is reached within a few steps, and it tests that wrapping follows the depth rather than the counter width. Load values are drawn from 0 to 15, so loads beyond the array are exercised as well. A long mixed run combines writes, soft resets, bank swaps, loads and steps in the same cycles. This reaches the priority rules between them.

// File: rtl/cam_cfg_pkg.sv
package cam_cfg_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD  = 2'b00,
    STEP_UP    = 2'b01,
    STEP_DOWN  = 2'b10,
    STEP_HOLD2 = 2'b11
  } step_e;

  localparam int WORD_W  = 15;
  localparam int STEP_LO = 2;
  localparam int RST_BIT = 15;
endpackage

// File: rtl/cam_cfg_bank.sv
module cam_cfg_bank #(
  parameter int W = 15,
  parameter logic [W-1:0] RST_WORD = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word <= RST_WORD;
    else if (clr)   word <= RST_WORD;
    else if (wr_en) word <= wr_data;
  end

  AST_CLR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> word == RST_WORD); // R2
endmodule

// File: rtl/cam_addr_step.sv
module cam_addr_step
  import cam_cfg_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          step_en,
  input  step_e         mode,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   LIM  = (AW+1)'(DEPTH);

  logic          ld_ok;
  logic [AW-1:0] nxt;

  assign ld_ok = ld && ({1'b0, ld_val} < LIM);

  always_comb begin
    nxt = addr;
    if (ld_ok) nxt = ld_val;
    else if (step_en) begin
      unique case (mode)
        STEP_UP:   nxt = (addr == LAST) ? '0 : addr + AW'(1);
        STEP_DOWN: nxt = (addr == '0) ? LAST : addr - AW'(1);
        default:   nxt = addr;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   addr <= '0;
    else if (clr) addr <= '0;
    else          addr <= nxt;
  end

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, addr} < LIM); // R7
  AST_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !ld && !clr && (mode == STEP_HOLD || mode == STEP_HOLD2)) |=> $stable(addr)); // R6
  AST_BAD_LOAD_NO_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr && !step_en && ({1'b0, ld_val} >= LIM)) |=> $stable(addr)); // R8
endmodule

// File: rtl/cam_cfg_seq.sv
module cam_cfg_seq
  import cam_cfg_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter logic [14:0] RST_WORD = 15'h0000,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [31:0]   ctl_wdata,
  input  logic [15:0]   status_hi,
  output logic [31:0]   ctl_rdata,
  input  logic          bank_set,
  input  logic          bank_val,
  input  logic          mem_access,
  input  logic          addr_ld,
  input  logic [AW-1:0] addr_ld_val,
  output logic [AW-1:0] addr_o,
  output logic [15:0]   cfg_o,
  output logic          cmp_req_o,
  output logic          soft_rst_o
);
  localparam int NBANK = 2;

  logic              sel;
  logic              do_rst;
  logic              do_store;
  logic [WORD_W-1:0] words [NBANK];
  logic [WORD_W-1:0] active;

  assign do_rst   = ctl_wr && !ctl_wdata[RST_BIT];
  assign do_store = ctl_wr &&  ctl_wdata[RST_BIT];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    cam_cfg_bank #(.W(WORD_W), .RST_WORD(RST_WORD)) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (do_rst),
      .wr_en   (do_store && (sel == 1'(b))),
      .wr_data (ctl_wdata[WORD_W-1:0]),
      .word    (words[b])
    );
  end

  assign active    = words[sel];
  assign cfg_o     = {1'b0, active};
  assign ctl_rdata = {status_hi, 1'b0, active};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel        <= 1'b0;
      cmp_req_o  <= 1'b0;
      soft_rst_o <= 1'b0;
    end else begin
      cmp_req_o  <= do_store;
      soft_rst_o <= do_rst;
      if (do_rst)        sel <= 1'b0;
      else if (bank_set) sel <= bank_val;
    end
  end

  cam_addr_step #(.DEPTH(DEPTH)) step_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (do_rst),
    .ld      (addr_ld),
    .ld_val  (addr_ld_val),
    .step_en (mem_access),
    .mode    (step_e'(active[STEP_LO +: 2])),
    .addr    (addr_o)
  );

  AST_RST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> !cmp_req_o); // R4
  AST_RST_FOREGROUND: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> (sel == 1'b0 && addr_o == '0)); // R2
  AST_RST_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_o && !$past(do_rst)) |-> 1'b0); // R2
  AST_BIT15_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[15] && cfg_o == ctl_rdata[15:0]); // R3
  AST_OTHER_BANK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (do_store && !bank_set) |=> $stable(words[~sel])); // R5
endmodule

// File: tb/cam_cfg_seq_tb_top.sv
module cam_cfg_seq_tb_top;
  localparam int D  = 12;
  localparam int AW = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic ctl_wr = 0;
  logic [31:0] ctl_wdata = '0;
  logic [15:0] status_hi = '0;
  logic [31:0] ctl_rdata;
  logic bank_set = 0, bank_val = 0, mem_access = 0, addr_ld = 0;
  logic [AW-1:0] addr_ld_val = '0;
  logic [AW-1:0] addr_o;
  logic [15:0] cfg_o;
  logic cmp_req_o, soft_rst_o;

  int checks = 0, failures = 0;
  int m_bank [2];
  int m_sel, m_addr, m_cmp, m_rst;
  int seed = 32'h1234_5678;
  bit done = 0;

  always #10 clk = ~clk;

  cam_cfg_seq #(.DEPTH(D), .RST_WORD(15'h0000)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .status_hi(status_hi), .ctl_rdata(ctl_rdata), .bank_set(bank_set),
    .bank_val(bank_val), .mem_access(mem_access), .addr_ld(addr_ld),
    .addr_ld_val(addr_ld_val), .addr_o(addr_o), .cfg_o(cfg_o),
    .cmp_req_o(cmp_req_o), .soft_rst_o(soft_rst_o));

  function automatic int rnd(int n);
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 8) & 32'h7fff_ffff) % n;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_bank[0] = 0; m_bank[1] = 0; m_sel = 0; m_addr = 0; m_cmp = 0; m_rst = 0;
    end else begin
      int st, na;
      bit srst;
      srst = ctl_wr && !ctl_wdata[15];
      st = (m_bank[m_sel] >> 2) & 3;
      na = m_addr;
      if (srst) na = 0;
      else if (addr_ld && addr_ld_val < D) na = addr_ld_val;
      else if (mem_access) begin
        if (st == 1) na = (m_addr + 1) % D;
        else if (st == 2) na = (m_addr + D - 1) % D;
      end
      m_addr = na;
      m_cmp = (ctl_wr && ctl_wdata[15]) ? 1 : 0;
      m_rst = srst ? 1 : 0;
      if (srst) begin
        m_bank[0] = 0; m_bank[1] = 0; m_sel = 0;
      end else begin
        if (ctl_wr) m_bank[m_sel] = ctl_wdata[14:0];
        if (bank_set) m_sel = bank_val;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) if (!done) begin
    chk("R3 status half", ctl_rdata[31:16], status_hi);
    chk("R3 bit15", ctl_rdata[15], 0);
    chk("R4 R5 active word", ctl_rdata[14:0], m_bank[m_sel]);
    chk("R3 cfg_o", cfg_o, m_bank[m_sel]);
    chk("R6 R7 R8 addr", addr_o, m_addr);
    chk("R4 cmp_req", cmp_req_o, m_cmp);
    chk("R2 soft_rst", soft_rst_o, m_rst);
  end

  task automatic idle();
    ctl_wr = 0; bank_set = 0; mem_access = 0; addr_ld = 0;
  endtask

  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic wr(logic [15:0] v);
    ctl_wr = 1; ctl_wdata = {16'hBEEF, v}; cyc(); idle();
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin mem_access = 1; cyc(); end
    idle();
  endtask

  initial begin
    #200000000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    status_hi = 16'hA5C3;
    repeat (3) @(negedge clk);
    chk("R1 reset addr", addr_o, 0);
    chk("R1 reset word", ctl_rdata[15:0], 0);
    #1 rst_n = 1;
    cyc();
    chk("R1 post-reset pulses", {cmp_req_o, soft_rst_o}, 0);
    // R4: store, compare pulse
    wr(16'h8005);                     // step up
    chk("R4 stored", cfg_o, 16'h0005);
    chk("R4 compare pulse", cmp_req_o, 1);
    cyc();
    chk("R4 one-shot", cmp_req_o, 0);
    // R6/R7: step up past the end
    addr_ld = 1; addr_ld_val = 4'd10; cyc(); idle();
    step(2);
    chk("R7 wrap up", addr_o, 0);
    // R8: out-of-range load ignored
    addr_ld = 1; addr_ld_val = 4'd13; cyc(); idle();
    chk("R8 bad load", addr_o, 0);
    // R5: background bank, step down
    bank_set = 1; bank_val = 1; cyc(); idle();
    chk("R5 background empty", cfg_o, 0);
    wr(16'h8009);                     // step down
    step(1);
    chk("R7 wrap down", addr_o, D - 1);
    bank_set = 1; bank_val = 0; cyc(); idle();
    chk("R5 foreground kept", cfg_o, 16'h0005);
    // R8: load beats step
    addr_ld = 1; addr_ld_val = 4'd3; mem_access = 1; cyc(); idle();
    chk("R8 load priority", addr_o, 3);
    // R6: hold encodings
    wr(16'h800C); step(3);
    chk("R6 hold 11", addr_o, 3);
    // R2: soft reset ignoring low bits, beats bank select
    ctl_wr = 1; ctl_wdata = 32'h0000_7FFF; bank_set = 1; bank_val = 1; cyc(); idle();
    chk("R2 soft reset pulse", soft_rst_o, 1);
    chk("R2 no compare", cmp_req_o, 0);
    chk("R2 word cleared", cfg_o, 0);
    chk("R2 addr cleared", addr_o, 0);
    cyc();
    chk("R2 one cycle", soft_rst_o, 0);
    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      ctl_wr = (rnd(4) == 0);
      ctl_wdata = {rnd(65536)[15:0], (rnd(10) == 0) ? 1'b0 : 1'b1, rnd(32768)[14:0]};
      bank_set = (rnd(6) == 0); bank_val = rnd(2)[0];
      mem_access = (rnd(2) == 0);
      addr_ld = (rnd(8) == 0); addr_ld_val = rnd(16)[3:0];
      status_hi = rnd(65536)[15:0];
      cyc();
    end
    idle();
    cyc();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule